// File: doc/BRIEF.md
# Prescaled Timer-Counter with Edge Select

This block is an 8-bit timer-counter fed through an optional 8-bit prescaler. Its count source is either an instruction-rate tick, made by dividing the oscillator clock by two or by four, or an external pin. The pin is brought into the clock domain by a two-flop synchroniser. An edge detector then picks either its rising or its falling transitions. A 3-bit ratio field sets how many source events make one counter step. A bypass bit sends each source event straight to the counter.

The instruction decoder reaches the block only through strobes. A register-write strobe loads the counter and empties the prescaler. A flag-clear strobe drops the overflow flag. A sleep input stops the internal source unless an analog conversion is running with its wake-enable set. The overflow flag goes up when the counter wraps from 0xFF to 0x00 and stays up until it is cleared.

Top module: `prescaled_timer`

## Requirements
- R1: After reset the counter reads 0x00 and the overflow flag is low.
- R2: The internal tick comes every 2 oscillator clocks when `clkDivSel` is 0 and every 4 when it is 1. With `bypassPre` at 1 and the internal source chosen, the counter advances by one per tick.
- R3: With `bypassPre` at 0, ratio code k (0 to 7) on `ratioSel` makes the counter advance once per 2^(k+1) source events. The codes give 2, 4, 8, 16, 32, 64, 128 and 256.
- R4: A cycle with `wrEn` high loads `wrData` into the counter and resets the prescaler to zero. The write wins over any increment in that cycle.
- R5: An increment from 0xFF to 0x00 sets `ovfFlag`. The flag holds until `ovfClr` is pulsed, and a set in the same cycle wins over the clear.
- R6: With `srcExt` at 1, the counter advances on the rising pin edge when `edgeFall` is 0 and on the falling pin edge when it is 1. The opposite edge has no effect. A pin level held for at least two clocks is counted within four clocks of the change.
- R7: While `sleep` is high, the internal source is frozen unless both `convActive` and `convWakeEn` are high. With both high, internal counting carries on at the normal rate.
- R8: The external source keeps counting while `sleep` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkDivSel | input | 1 | Instruction tick divider: 0 gives /2, 1 gives /4 |
| srcExt | input | 1 | Count source: 0 internal tick, 1 external pin |
| edgeFall | input | 1 | Pin edge select: 0 rising, 1 falling |
| bypassPre | input | 1 | 1 routes source events past the prescaler |
| ratioSel | input | 3 | Prescale code k, divide by 2^(k+1) |
| pinIn | input | 1 | Asynchronous external count pin |
| wrEn | input | 1 | Counter write strobe |
| wrData | input | 8 | Value loaded by the write strobe |
| sleep | input | 1 | Sleep state |
| convActive | input | 1 | Analog conversion in progress |
| convWakeEn | input | 1 | Conversion wake-enable bit |
| ovfClr | input | 1 | Overflow flag clear strobe |
| count | output | 8 | Counter value |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
Each vector writes the counter and then waits a window whose length is a whole number of prescaled periods. A prescaler that a write fails to empty, or a mask that is off by one ratio code, lands on the wrong final value. The wrap from 0xFE is sampled one tick before and one tick after 0x00. This catches a flag that fires early or one that a later clear cannot drop. Sleep runs are checked three ways: the internal count must hold still, must run when a wake-enabled conversion is active, and must keep taking pin edges. A design that gates the wrong source shows up in one of these. Pin pulses of both polarities go through each edge setting, so a detector that counts both edges, or the wrong one, gives an off count.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int CNT_W = 8;
  localparam int PRE_W = 8;
  localparam int RATIO_W = $clog2(PRE_W);

  typedef struct packed {
    logic srcEvent;
    logic load;
    logic flagClr;
  } ctrlStrobes_t;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clkDivSel,
  input  logic         srcExt,
  input  logic         edgeFall,
  input  logic         pinIn,
  input  logic         sleep,
  input  logic         convActive,
  input  logic         convWakeEn,
  input  logic         wrEn,
  input  logic         ovfClr,
  output ctrlStrobes_t strobes
);
  logic [1:0] divCnt;
  logic [1:0] divLast;
  logic runInt;
  logic instrTick;
  logic [SYNC_STAGES-1:0] syncQ;
  logic pinPrev;
  logic pinRise;
  logic pinFall;
  logic pinEdge;

  assign divLast = clkDivSel ? 2'd3 : 2'd1;
  assign runInt = !sleep || (convActive && convWakeEn);
  assign instrTick = runInt && (divCnt >= divLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (runInt) begin
      if (divCnt >= divLast) divCnt <= '0;
      else divCnt <= divCnt + 2'd1;
    end
  end

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else syncQ <= pinIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= 1'b0;
    else pinPrev <= syncQ[SYNC_STAGES-1];
  end

  assign pinRise = syncQ[SYNC_STAGES-1] && !pinPrev;
  assign pinFall = !syncQ[SYNC_STAGES-1] && pinPrev;
  assign pinEdge = edgeFall ? pinFall : pinRise;

  always_comb begin
    strobes.srcEvent = srcExt ? pinEdge : instrTick;
    strobes.load = wrEn;
    strobes.flagClr = ovfClr;
  end

  // R6
  edge_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    pinEdge |=> !pinEdge);

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    instrTick |=> !instrTick);
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic               bypassPre,
  input  logic [RATIO_W-1:0] ratioSel,
  input  logic [CNT_W-1:0]   wrData,
  output logic [CNT_W-1:0]   count,
  output logic               ovfFlag
);
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMask;
  logic incEn;
  logic wrapNow;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) preMask[i] = (i <= int'(ratioSel));
  end

  assign incEn = strobes.srcEvent && (bypassPre || ((preCnt & preMask) == preMask));
  assign wrapNow = incEn && !strobes.load && (count == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      count <= '0;
    end else if (strobes.load) begin
      preCnt <= '0;
      count <= wrData;
    end else begin
      if (strobes.srcEvent && !bypassPre) preCnt <= preCnt + 1'b1;
      if (incEn) count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ovfFlag <= 1'b0;
    else if (wrapNow) ovfFlag <= 1'b1;
    else if (strobes.flagClr) ovfFlag <= 1'b0;
  end

  // R4
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (count == $past(wrData)) && (preCnt == '0));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> (count == $past(count)) || (count == $past(count) + 1'b1));

  // R5
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrapNow |=> ovfFlag && (count == '0));

  // R5
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !strobes.flagClr) |=> ovfFlag);
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import timer_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               clkDivSel,
  input  logic               srcExt,
  input  logic               edgeFall,
  input  logic               bypassPre,
  input  logic [RATIO_W-1:0] ratioSel,
  input  logic               pinIn,
  input  logic               wrEn,
  input  logic [CNT_W-1:0]   wrData,
  input  logic               sleep,
  input  logic               convActive,
  input  logic               convWakeEn,
  input  logic               ovfClr,
  output logic [CNT_W-1:0]   count,
  output logic               ovfFlag
);
  ctrlStrobes_t strobes;

  timer_ctrl #(.SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .clkDivSel(clkDivSel), .srcExt(srcExt),
    .edgeFall(edgeFall), .pinIn(pinIn), .sleep(sleep),
    .convActive(convActive), .convWakeEn(convWakeEn), .wrEn(wrEn),
    .ovfClr(ovfClr), .strobes(strobes)
  );

  timer_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .bypassPre(bypassPre),
    .ratioSel(ratioSel), .wrData(wrData), .count(count), .ovfFlag(ovfFlag)
  );

  // R7
  sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sleep && !(convActive && convWakeEn) && !srcExt && !wrEn) |=> $stable(count));
endmodule

// File: tb/prescaled_timer_test.sv
module prescaled_timer_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clkDivSel = 1'b0;
  logic srcExt = 1'b0;
  logic edgeFall = 1'b0;
  logic bypassPre = 1'b1;
  logic [2:0] ratioSel = 3'd0;
  logic pinIn = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic sleep = 1'b0;
  logic convActive = 1'b0;
  logic convWakeEn = 1'b0;
  logic ovfClr = 1'b0;
  logic [7:0] count;
  logic ovfFlag;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prescaled_timer uut (
    .clk(clk), .rstN(rstN), .clkDivSel(clkDivSel), .srcExt(srcExt),
    .edgeFall(edgeFall), .bypassPre(bypassPre), .ratioSel(ratioSel),
    .pinIn(pinIn), .wrEn(wrEn), .wrData(wrData), .sleep(sleep),
    .convActive(convActive), .convWakeEn(convWakeEn), .ovfClr(ovfClr),
    .count(count), .ovfFlag(ovfFlag)
  );

  // fields: clkDivSel, bypassPre, ratioSel[3], wrVal[8], cycles[12], expected[8]
  localparam int NVEC = 6;
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 3'd0, 8'h0A, 12'd20,   8'h14},
    {1'b1, 1'b1, 3'd0, 8'h00, 12'd40,   8'h0A},
    {1'b0, 1'b0, 3'd0, 8'h05, 12'd40,   8'h0F},
    {1'b1, 1'b0, 3'd2, 8'h30, 12'd96,   8'h33},
    {1'b0, 1'b0, 3'd7, 8'h00, 12'd1024, 8'h02},
    {1'b0, 1'b0, 3'd3, 8'hF0, 12'd128,  8'hF4}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] val);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    waitClk(3);
    check("R1 count", count, 8'h00);
    check("R1 flag", {7'd0, ovfFlag}, 8'h00);
    rstN = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      clkDivSel = VEC[v][32];
      bypassPre = VEC[v][31];
      ratioSel = VEC[v][30:28];
      doWrite(VEC[v][27:20]);
      waitClk(int'(VEC[v][19:8]));
      check(VEC[v][31] ? "R2 vector" : "R3 vector", count, VEC[v][7:0]);
    end

    // R4: held write wins over ticks that land in the same cycles
    clkDivSel = 1'b0; bypassPre = 1'b1;
    @(negedge clk);
    wrEn = 1'b1; wrData = 8'h77;
    waitClk(3);
    wrEn = 1'b0;
    check("R4 write priority", count, 8'h77);

    // R5: wrap from 0xFE
    doWrite(8'hFE);
    waitClk(2);
    check("R5 before wrap count", count, 8'hFF);
    check("R5 before wrap flag", {7'd0, ovfFlag}, 8'h00);
    waitClk(2);
    check("R5 wrap count", count, 8'h00);
    check("R5 wrap flag", {7'd0, ovfFlag}, 8'h01);
    sleep = 1'b1;
    waitClk(20);
    check("R5 flag sticky", {7'd0, ovfFlag}, 8'h01);
    ovfClr = 1'b1;
    @(negedge clk);
    ovfClr = 1'b0;
    check("R5 flag cleared", {7'd0, ovfFlag}, 8'h00);

    // R7: sleep freezes internal source
    doWrite(8'h20);
    waitClk(40);
    check("R7 frozen", count, 8'h20);
    convActive = 1'b1;
    waitClk(20);
    check("R7 no wake enable", count, 8'h20);
    convWakeEn = 1'b1;
    doWrite(8'h00);
    waitClk(20);
    check("R7 conversion wake", count, 8'h0A);
    sleep = 1'b0; convActive = 1'b0; convWakeEn = 1'b0;

    // R6: external edges
    srcExt = 1'b1; edgeFall = 1'b0; bypassPre = 1'b1;
    doWrite(8'h00);
    pinIn = 1'b1; waitClk(4);
    check("R6 rising counted", count, 8'h01);
    pinIn = 1'b0; waitClk(4);
    check("R6 falling ignored", count, 8'h01);
    edgeFall = 1'b1;
    pinIn = 1'b1; waitClk(4);
    check("R6 rising ignored", count, 8'h01);
    pinIn = 1'b0; waitClk(4);
    check("R6 falling counted", count, 8'h02);

    // R8: external source runs in sleep
    sleep = 1'b1;
    pinIn = 1'b1; waitClk(4);
    pinIn = 1'b0; waitClk(4);
    check("R8 external in sleep", count, 8'h03);
    sleep = 1'b0;

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule